// File: doc/BRIEF.md
# MDIO Management Command Controller

This block lets a host read and write PHY registers over the two-wire MII management bus. The host loads a write-data register and then a command register that holds a PHY address, a register address and a read or write start bit. The controller sends a clause-22 management frame on MDC/MDIO and drives a separate output-enable for the bidirectional data pin. It clears the start bit when the frame ends. After a read, the 16 bits returned by the PHY appear in the low half of the same command register.

The host side is a plain single-cycle register port, with no valid/ready handshake and no back-pressure. Every write strobe completes in the cycle it is presented. A command write that arrives while a frame is running is dropped, so software polls the start bits before it issues the next command. MDC is divided from the system clock by the parameter `MDC_HALF_DIV`. A frame takes 128 × `MDC_HALF_DIV` system cycles. With a 125 MHz clock, any divider up to several hundred keeps one operation well inside 1 ms.

Top module: `mdio_cmd_ctrl`

## Requirements
- R1: After reset, both registers read zero, MDC is low and `mdio_oe` is low.
- R2: MDC is low whenever no frame is running. During a frame, each high phase and each low phase of MDC lasts exactly `MDC_HALF_DIV` system cycles.
- R3: A frame carries, MSB first, the following fields:
  - 32 ones;
  - start pattern 01;
  - opcode 01 for a write or 10 for a read;
  - the 5-bit PHY address;
  - the 5-bit register address;
  - turnaround 10 on a write;
  - 16 data bits, which on a write come from the write-data register.
  
  MDIO changes only while MDC is low, and the PHY samples it on the rising MDC edge.
- R4: On a write, `mdio_oe` stays high for all 64 bits. On a read, `mdio_oe` is high for the first 46 bits and low from the turnaround onward. `mdio_oe` is never high outside a frame.
- R5: On a read, `mdio_i` is sampled on the rising MDC edge of each of the last 16 bits, MSB first. The 16-bit result lands in command bits [15:0] when the frame ends. A host write to the command register never changes bits [15:0].
- R6: The accepted start bit reads back as 1 while the frame runs. It clears exactly 128 × `MDC_HALF_DIV` cycles after the clock edge that accepted the command.
- R7: A command-register write that arrives while a start bit is set has no effect on the register and starts no frame.
- R8: If a command sets both start bits, a read is performed, and only the read start bit is stored.
- R9: Register map:
  - `host_addr` 0 is the command register: [15:0] read data, [20:16] PHY address, [25:21] register address, bit 26 read start, bit 27 write start, [31:28] always zero.
  - `host_addr` 1 is the write-data register, with its data in [15:0] and [31:16] reading zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| host_we | input | 1 | Register write strobe, one cycle per write |
| host_addr | input | 1 | Register select: 0 command, 1 write data |
| host_wdata | input | 32 | Write value |
| host_rdata | output | 32 | Combinational read of the selected register |
| mdc | output | 1 | Management clock |
| mdio_o | output | 1 | Management data out |
| mdio_oe | output | 1 | Drive enable for the data pin (1 = drive) |
| mdio_i | input | 1 | Management data in from the pin |

## Verification
The assertions assume that the host strobes `host_we` for one cycle at a time and that `MDC_HALF_DIV` is at least 1. They also assume that `mdio_i` matters only in the data phase of a read. The bench therefore moves its PHY model's `mdio_i` only just after a falling MDC edge, so the value is settled well before the controller samples it. All host writes are made at the falling system-clock edge, so each command is accepted on a known rising edge and the completion edge can be counted from it.

// File: rtl/mdio_pkg.sv
package mdio_pkg;
  localparam int CMD_DATA_LSB = 0;
  localparam int CMD_PHY_LSB  = 16;
  localparam int CMD_REG_LSB  = 21;
  localparam int CMD_RD_BIT   = 26;
  localparam int CMD_WR_BIT   = 27;
  localparam int ADDR_W       = 5;
  localparam int DATA_W       = 16;

  typedef enum logic [1:0] {
    OP_WRITE = 2'b01,
    OP_READ  = 2'b10
  } mdio_op_e;
endpackage

// File: rtl/mdio_mdc_gen.sv
module mdio_mdc_gen #(
  parameter int HALF_DIV = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  output logic mdc,
  output logic rise_tick,
  output logic fall_tick
);
  localparam int CW = (HALF_DIV > 1) ? $clog2(HALF_DIV) : 1;

  logic [CW-1:0] cnt;
  logic          tick;

  assign tick      = run && (cnt == CW'(HALF_DIV - 1));
  assign rise_tick = tick & ~mdc;
  assign fall_tick = tick & mdc;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt <= '0;
      mdc <= 1'b0;
    end else if (!run) begin
      cnt <= '0;
      mdc <= 1'b0;
    end else if (tick) begin
      cnt <= '0;
      mdc <= ~mdc;
    end else begin
      cnt <= cnt + CW'(1);
    end
  end
endmodule

// File: rtl/mdio_frame_seq.sv
module mdio_frame_seq
  import mdio_pkg::*;
#(
  parameter int PRE_LEN = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              start_read,
  input  logic [ADDR_W-1:0] phy_addr,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [DATA_W-1:0] wdata,
  input  logic              rise_tick,
  input  logic              fall_tick,
  input  logic              mdio_i,
  output logic              busy,
  output logic              done,
  output logic              mdio_o,
  output logic              mdio_oe,
  output logic [DATA_W-1:0] rdata
);
  localparam int FRAME_LEN = PRE_LEN + 2 + 2 + 2 * ADDR_W + 2 + DATA_W;
  localparam int IW        = $clog2(FRAME_LEN);
  localparam int TA_IDX    = PRE_LEN + 4 + 2 * ADDR_W;
  localparam int DATA_IDX  = TA_IDX + 2;

  logic [FRAME_LEN-1:0] shreg;
  logic [IW-1:0]        idx;
  logic                 rd_q;
  logic [DATA_W-1:0]    cap;
  logic                 last;
  mdio_op_e             op;

  assign op   = start_read ? OP_READ : OP_WRITE;
  assign last = (idx == IW'(FRAME_LEN - 1));
  assign done = busy && fall_tick && last;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy  <= 1'b0;
      idx   <= '0;
      rd_q  <= 1'b0;
      shreg <= '0;
      cap   <= '0;
    end else if (start) begin
      busy  <= 1'b1;
      idx   <= '0;
      rd_q  <= start_read;
      cap   <= '0;
      shreg <= {{PRE_LEN{1'b1}}, 2'b01, op, phy_addr, reg_addr,
                (start_read ? 2'b11 : 2'b10),
                (start_read ? {DATA_W{1'b0}} : wdata)};
    end else if (busy && rise_tick) begin
      if (rd_q && idx >= IW'(DATA_IDX))
        cap <= {cap[DATA_W-2:0], mdio_i};
    end else if (busy && fall_tick) begin
      if (last) begin
        busy <= 1'b0;
      end else begin
        idx   <= idx + IW'(1);
        shreg <= shreg << 1;
      end
    end
  end

  assign mdio_o  = busy & shreg[FRAME_LEN-1];
  assign mdio_oe = busy && !(rd_q && idx >= IW'(TA_IDX));
  assign rdata   = cap;
endmodule

// File: rtl/mdio_host_regs.sv
module mdio_host_regs
  import mdio_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              host_we,
  input  logic              host_addr,
  input  logic [31:0]       host_wdata,
  output logic [31:0]       host_rdata,
  input  logic              done,
  input  logic [DATA_W-1:0] rdata_in,
  output logic              start,
  output logic              start_read,
  output logic [ADDR_W-1:0] phy_addr,
  output logic [ADDR_W-1:0] reg_addr,
  output logic [DATA_W-1:0] wdata_q,
  output logic [31:0]       cmd_q
);
  logic pending;
  logic accept;
  logic rd_req;
  logic wr_req;
  logic unused_bits;

  assign pending    = cmd_q[CMD_RD_BIT] | cmd_q[CMD_WR_BIT];
  assign accept     = host_we && !host_addr && !pending;
  assign rd_req     = host_wdata[CMD_RD_BIT];
  assign wr_req     = host_wdata[CMD_WR_BIT] & ~rd_req;
  assign start      = accept && (rd_req || wr_req);
  assign start_read = rd_req;
  assign phy_addr   = host_wdata[CMD_PHY_LSB +: ADDR_W];
  assign reg_addr   = host_wdata[CMD_REG_LSB +: ADDR_W];
  assign unused_bits = ^{host_wdata[31:28], host_wdata[15:0], host_wdata[31:16]};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cmd_q   <= '0;
      wdata_q <= '0;
    end else begin
      if (host_we && host_addr)
        wdata_q <= host_wdata[DATA_W-1:0];
      if (accept) begin
        cmd_q[CMD_PHY_LSB +: ADDR_W] <= phy_addr;
        cmd_q[CMD_REG_LSB +: ADDR_W] <= reg_addr;
        cmd_q[CMD_RD_BIT]            <= rd_req;
        cmd_q[CMD_WR_BIT]            <= wr_req;
      end else if (done) begin
        if (cmd_q[CMD_RD_BIT])
          cmd_q[CMD_DATA_LSB +: DATA_W] <= rdata_in;
        cmd_q[CMD_RD_BIT] <= 1'b0;
        cmd_q[CMD_WR_BIT] <= 1'b0;
      end
    end
  end

  assign host_rdata = host_addr ? {16'h0, wdata_q} : cmd_q;
endmodule

// File: rtl/mdio_cmd_ctrl.sv
module mdio_cmd_ctrl
  import mdio_pkg::*;
#(
  parameter int MDC_HALF_DIV = 4,
  parameter int PREAMBLE_LEN = 32
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        host_we,
  input  logic        host_addr,
  input  logic [31:0] host_wdata,
  output logic [31:0] host_rdata,
  output logic        mdc,
  output logic        mdio_o,
  output logic        mdio_oe,
  input  logic        mdio_i
);
  logic              start;
  logic              start_read;
  logic [ADDR_W-1:0] phy_addr;
  logic [ADDR_W-1:0] reg_addr;
  logic [DATA_W-1:0] wdata_q;
  logic [DATA_W-1:0] seq_rdata;
  logic [31:0]       cmd_q;
  logic              seq_busy;
  logic              seq_done;
  logic              rise_tick;
  logic              fall_tick;

  mdio_host_regs u_regs (
    .clk(clk), .rst_n(rst_n), .host_we(host_we), .host_addr(host_addr),
    .host_wdata(host_wdata), .host_rdata(host_rdata), .done(seq_done),
    .rdata_in(seq_rdata), .start(start), .start_read(start_read),
    .phy_addr(phy_addr), .reg_addr(reg_addr), .wdata_q(wdata_q), .cmd_q(cmd_q)
  );

  mdio_mdc_gen #(.HALF_DIV(MDC_HALF_DIV)) u_mdc (
    .clk(clk), .rst_n(rst_n), .run(seq_busy), .mdc(mdc),
    .rise_tick(rise_tick), .fall_tick(fall_tick)
  );

  mdio_frame_seq #(.PRE_LEN(PREAMBLE_LEN)) u_seq (
    .clk(clk), .rst_n(rst_n), .start(start), .start_read(start_read),
    .phy_addr(phy_addr), .reg_addr(reg_addr), .wdata(wdata_q),
    .rise_tick(rise_tick), .fall_tick(fall_tick), .mdio_i(mdio_i),
    .busy(seq_busy), .done(seq_done), .mdio_o(mdio_o), .mdio_oe(mdio_oe),
    .rdata(seq_rdata)
  );
endmodule

// File: rtl/mdio_cmd_ctrl_chk.sv
module mdio_cmd_ctrl_chk
  import mdio_pkg::*;
(
  input logic        clk,
  input logic        rst_n,
  input logic        mdc,
  input logic        mdio_o,
  input logic        mdio_oe,
  input logic        busy,
  input logic [31:0] cmd_q
);
  // R2: clock parked low outside a frame
  a_r2_mdc_idle_low: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !mdc);

  // R4: pin driven only inside a frame
  a_r4_oe_only_busy: assert property (@(posedge clk) disable iff (!rst_n)
    mdio_oe |-> busy);

  // R3: data held steady while MDC is high
  a_r3_data_stable_high: assert property (@(posedge clk) disable iff (!rst_n)
    (mdc && $past(mdc)) |-> $stable(mdio_o));

  // R6: start bits gone once the frame ends
  a_r6_start_clears: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> (cmd_q[CMD_RD_BIT] == 1'b0 && cmd_q[CMD_WR_BIT] == 1'b0));

  // R7: addresses frozen during a frame
  a_r7_fields_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy)) |-> $stable(cmd_q[CMD_REG_LSB+ADDR_W-1:CMD_PHY_LSB]));
endmodule

bind mdio_cmd_ctrl mdio_cmd_ctrl_chk u_chk (
  .clk(clk), .rst_n(rst_n), .mdc(mdc), .mdio_o(mdio_o), .mdio_oe(mdio_oe),
  .busy(seq_busy), .cmd_q(cmd_q)
);

// File: tb/mdio_cmd_ctrl_tb.sv
`timescale 1ns/1ps
module mdio_cmd_ctrl_tb;
  localparam int HD = 4;
  localparam int FRAME_CYC = 128 * HD;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        host_we = 1'b0;
  logic        host_addr = 1'b0;
  logic [31:0] host_wdata = '0;
  logic [31:0] host_rdata;
  logic        mdc, mdio_o, mdio_oe;
  logic        mdio_i = 1'b1;

  int checks = 0;
  int errors = 0;
  int frames_seen = 0;
  bit finished = 0;

  logic [63:0] exp_frame_q[$];
  logic [63:0] exp_mask_q[$];
  logic [63:0] obs_bits, obs_oe;
  int          nrise = 0;
  logic [15:0] phy_data = 16'h0;

  always #4 clk = ~clk;

  mdio_cmd_ctrl #(.MDC_HALF_DIV(HD)) u_dut (
    .clk(clk), .rst_n(rst_n), .host_we(host_we), .host_addr(host_addr),
    .host_wdata(host_wdata), .host_rdata(host_rdata), .mdc(mdc),
    .mdio_o(mdio_o), .mdio_oe(mdio_oe), .mdio_i(mdio_i)
  );

  task automatic check(input bit ok, input string tag, input logic [63:0] act,
                       input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic host_write(input logic a, input logic [31:0] d);
    @(negedge clk);
    host_we = 1'b1; host_addr = a; host_wdata = d;
    @(negedge clk);
    host_we = 1'b0; host_wdata = '0;
  endtask

  task automatic host_read(input logic a, output logic [31:0] v);
    host_addr = a;
    #1;
    v = host_rdata;
  endtask

  function automatic logic [31:0] mk_cmd(input bit rd, input bit wr,
                                         input logic [4:0] phy, input logic [4:0] rg,
                                         input logic [15:0] low);
    return {4'b0, wr, rd, rg, phy, low};
  endfunction

  // driver side of the scoreboard
  task automatic expect_frame(input bit rd, input logic [4:0] phy,
                              input logic [4:0] rg, input logic [15:0] wd);
    exp_frame_q.push_back({32'hFFFF_FFFF, 2'b01, (rd ? 2'b10 : 2'b01), phy, rg,
                           (rd ? 2'b00 : 2'b10), (rd ? 16'h0 : wd)});
    exp_mask_q.push_back(rd ? {{46{1'b1}}, 18'b0} : {64{1'b1}});
  endtask

  // monitor: gathers each bit at the rising MDC edge
  always @(posedge mdc) begin
    obs_bits[63-nrise] = mdio_o;
    obs_oe[63-nrise]   = mdio_oe;
    nrise++;
    if (nrise == 64) begin
      logic [63:0] ef, em;
      nrise = 0;
      frames_seen++;
      if (exp_frame_q.size() == 0) begin
        check(1'b0, "R7 unexpected frame", obs_bits, 64'h0);
      end else begin
        ef = exp_frame_q.pop_front();
        em = exp_mask_q.pop_front();
        check((obs_bits & em) == (ef & em), "R3 frame bits", obs_bits & em, ef & em);
        check(obs_oe == em, "R4 drive enable pattern", obs_oe, em);
      end
    end
  end

  // PHY model: returns read data after each falling MDC edge
  always @(negedge mdc) begin
    if (nrise >= 48 && nrise < 64 && obs_bits[63-34] && !obs_bits[63-35])
      mdio_i = phy_data[63-nrise];
    else
      mdio_i = 1'b1;
  end

  initial begin
    #(200000 * 8);
    if (!finished) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired actual=hung expected=done");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [31:0] v;
    int n;
    repeat (3) @(negedge clk);
    // R1 reset state
    host_read(1'b0, v); check(v == 32'h0, "R1 cmd reset", v, 0);
    host_read(1'b1, v); check(v == 32'h0, "R1 wdata reset", v, 0);
    check(mdc == 1'b0 && mdio_oe == 1'b0, "R1 pins reset", {mdc, mdio_oe}, 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    // R9 write-data register
    host_write(1'b1, 32'hDEAD_A5C3);
    host_read(1'b1, v); check(v == 32'h0000_A5C3, "R9 wdata readback", v, 32'hA5C3);

    // R3 R6 write frame with exact completion timing
    expect_frame(1'b0, 5'h11, 5'h04, 16'hA5C3);
    host_write(1'b0, mk_cmd(0, 1, 5'h11, 5'h04, 16'h0));
    host_read(1'b0, v);
    check(v == mk_cmd(0, 1, 5'h11, 5'h04, 16'h0), "R9 cmd field positions", v,
          mk_cmd(0, 1, 5'h11, 5'h04, 16'h0));
    repeat (FRAME_CYC - 1) @(negedge clk);
    host_read(1'b0, v); check(v[27] == 1'b1, "R6 start bit held", v[27], 1);
    @(negedge clk);
    host_read(1'b0, v); check(v[27:26] == 2'b00, "R6 start bit cleared", v[27:26], 0);
    check(mdc == 1'b0 && mdio_oe == 1'b0, "R2 idle after frame", {mdc, mdio_oe}, 0);
    check(frames_seen == 1, "R3 one frame sent", frames_seen, 1);

    // R5 R2 read frame, measure MDC high phase
    phy_data = 16'h3C5A;
    expect_frame(1'b1, 5'h01, 5'h1F, 16'h0);
    host_write(1'b0, mk_cmd(1, 0, 5'h01, 5'h1F, 16'h0));
    @(posedge mdc); @(negedge clk);
    n = 0;
    while (mdc) begin n++; @(negedge clk); end
    check(n == HD, "R2 MDC high phase", n, HD);
    n = 0;
    while (!mdc) begin n++; @(negedge clk); end
    check(n == HD, "R2 MDC low phase", n, HD);
    repeat (FRAME_CYC) @(negedge clk);
    host_read(1'b0, v);
    check(v == mk_cmd(0, 0, 5'h01, 5'h1F, 16'h3C5A), "R5 read data in cmd", v,
          mk_cmd(0, 0, 5'h01, 5'h1F, 16'h3C5A));

    // R7 command during a frame is dropped
    host_write(1'b1, 32'h0000_1234);
    expect_frame(1'b0, 5'h02, 5'h03, 16'h1234);
    host_write(1'b0, mk_cmd(0, 1, 5'h02, 5'h03, 16'h0));
    repeat (20) @(negedge clk);
    host_write(1'b0, mk_cmd(1, 0, 5'h09, 5'h09, 16'h0));
    host_read(1'b0, v);
    check(v == mk_cmd(0, 1, 5'h02, 5'h03, 16'h3C5A), "R7 busy write ignored", v,
          mk_cmd(0, 1, 5'h02, 5'h03, 16'h3C5A));
    repeat (FRAME_CYC + 200) @(negedge clk);
    check(frames_seen == 3 && exp_frame_q.size() == 0, "R7 no extra frame",
          frames_seen, 3);

    // R8 both start bits -> read
    phy_data = 16'h8001;
    expect_frame(1'b1, 5'h1E, 5'h00, 16'h0);
    host_write(1'b0, mk_cmd(1, 1, 5'h1E, 5'h00, 16'h0));
    host_read(1'b0, v);
    check(v[27:26] == 2'b01, "R8 only read bit kept", v[27:26], 2'b01);
    repeat (FRAME_CYC + 10) @(negedge clk);
    host_read(1'b0, v);
    check(v[15:0] == 16'h8001, "R8 read result", v[15:0], 16'h8001);

    // R5 low half not host-writable; no start bits -> no frame (R2)
    host_write(1'b0, mk_cmd(0, 0, 5'h05, 5'h06, 16'hFFFF));
    repeat (50) @(negedge clk);
    host_read(1'b0, v);
    check(v == mk_cmd(0, 0, 5'h05, 5'h06, 16'h8001), "R5 low half read-only", v,
          mk_cmd(0, 0, 5'h05, 5'h06, 16'h8001));
    check(mdc == 1'b0 && frames_seen == 4, "R2 no frame without start", frames_seen, 4);

    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule